// File: doc/BRIEF.md
# SCL Bit-Rate and Setup-Delay Generator

This block derives the serial clock timing of an I2C master from the system clock. Software supplies a 2-bit speed selector and one 32-bit divider word. The word carries two independent 16-bit unit lengths. The selector picks which length applies and how many units make up one SCL period. The generator drives a registered SCL level. It also emits a one-cycle strobe at the start of every low unit and another at the start of the high unit, so that the shifter can move data on them.

A second, separate timer measures the data setup delay that must elapse after the bus has been released from clock stretching. Its length comes from the upper half of a 32-bit setup word. The timer is armed by a release pulse and reports completion with a one-cycle pulse.

Top module: `scl_rate_gen`

## Requirements
- R1: While `enable` is low at a clock edge, after that edge `sclLevel` is 1 and `lowTick`, `highTick` and `setupDone` are 0. Reset gives the same state.
- R2: The speed selector codes are 0 standard, 1 fast, 2 high-speed and 3 fast-plus. In code 2 the unit length U is `divWord[31:16]`; in every other code it is `divWord[15:0]`.
- R3: In standard mode one period is 2·U cycles: U cycles with `sclLevel` low, then U cycles high.
- R4: In fast, fast-plus and high-speed modes one period is 3·U cycles: 2·U cycles low, then U cycles high.
- R5: `lowTick` pulses for one cycle in the first cycle of each low unit, and `highTick` in the first cycle of the high unit. The two never pulse together.
- R6: A selected unit length of 0 behaves as a length of 1.
- R7: A change to `divWord` or `speedMode` during operation takes effect only at the start of the next period.
- R8: At the first edge where `enable` is high after being low, a period starts: `sclLevel` goes low and `lowTick` pulses, using the divider and mode present at that edge.
- R9: A `stretchRelease` pulse sampled at edge e, with S = `setupWord[31:16]`, makes `setupDone` pulse for one cycle after edge e+S+1. So S = 0 waits one cycle. `setupWord[15:0]` has no effect.
- R10: A `stretchRelease` while the setup timer is running restarts it from the current S. A pulse that would coincide with the release is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low holds all counters idle |
| speedMode | input | 2 | Speed selector (0 std, 1 fast, 2 high-speed, 3 fast-plus) |
| divWord | input | 32 | Divider word: high-speed length in 31:16, other modes in 15:0 |
| setupWord | input | 32 | Setup word: delay count in 31:16 |
| stretchRelease | input | 1 | Pulse that arms the setup-delay timer |
| sclLevel | output | 1 | Registered SCL level, 1 when released |
| lowTick | output | 1 | Strobe at the start of each low unit |
| highTick | output | 1 | Strobe at the start of the high unit |
| setupDone | output | 1 | One-cycle pulse when the setup delay has elapsed |

## Verification
The assertions assume that `enable`, `speedMode`, `divWord`, `setupWord` and `stretchRelease` are synchronous to `clk` and steady around its rising edge. They also take `stretchRelease` to be a qualifying pulse and not a level held against a count of zero. The stimulus changes every input just after a falling edge. It drives release pulses one cycle wide, except for the deliberate back-to-back re-arm case. Mode and divider changes are applied both mid-period and across a disable, so the deferred-update behaviour is exercised in both of its forms.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_HIGH  = 2'd2,
    SPD_FPLUS = 2'd3
  } speedSel_e;

  // strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic holdIdle;   // peripheral disabled: clear everything
    logic latchCfg;   // capture unit length and phase count (period start)
    logic startUnit;  // restart the unit counter
    logic stepUnit;   // advance the unit counter
    logic armSetup;   // (re)load the setup-delay timer
  } dpStrobe_t;

endpackage

// File: rtl/sclgen_dp.sv
module sclgen_dp
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        speedMode,
  input  logic [WORD_W-1:0] divWord,
  input  logic [WORD_W-1:0] setupWord,
  output logic              unitLast,
  output logic [1:0]        lastPhaseIdx,
  output logic              setupDone
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] selCount;
  logic [CNT_W-1:0] unitNext;
  logic [1:0]       phasesNext;
  logic [CNT_W-1:0] unitLen;
  logic [CNT_W-1:0] unitCnt;
  logic [CNT_W-1:0] setupLeft;
  logic             setupBusy;

  // pick the divider half for the selected mode; zero counts as one
  always_comb begin
    if (speedSel_e'(speedMode) == SPD_HIGH)
      selCount = divWord[WORD_W-1 -: CNT_W];
    else
      selCount = divWord[CNT_W-1:0];
    unitNext   = (selCount == '0) ? ONE : selCount;
    phasesNext = (speedSel_e'(speedMode) == SPD_STD) ? 2'd1 : 2'd2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitLen      <= ONE;
      lastPhaseIdx <= 2'd1;
    end else if (strobe.latchCfg) begin
      unitLen      <= unitNext;
      lastPhaseIdx <= phasesNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 unitCnt <= '0;
    else if (strobe.holdIdle)  unitCnt <= '0;
    else if (strobe.startUnit) unitCnt <= '0;
    else if (strobe.stepUnit)  unitCnt <= unitCnt + ONE;
  end

  assign unitLast = (unitCnt == unitLen - ONE);

  // setup-delay timer: count + 1 cycles from the arming edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupLeft <= '0;
      setupBusy <= 1'b0;
      setupDone <= 1'b0;
    end else if (strobe.holdIdle) begin
      setupLeft <= '0;
      setupBusy <= 1'b0;
      setupDone <= 1'b0;
    end else if (strobe.armSetup) begin
      setupLeft <= setupWord[WORD_W-1 -: CNT_W];
      setupBusy <= 1'b1;
      setupDone <= 1'b0;
    end else if (setupBusy && setupLeft == '0) begin
      setupBusy <= 1'b0;
      setupDone <= 1'b1;
    end else begin
      if (setupBusy) setupLeft <= setupLeft - ONE;
      setupDone <= 1'b0;
    end
  end

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       stretchRelease,
  input  logic       unitLast,
  input  logic [1:0] lastPhaseIdx,
  output dpStrobe_t  strobe,
  output logic       sclLevel,
  output logic       lowTick,
  output logic       highTick
);

  logic       running;
  logic [1:0] phaseIdx;
  logic       atStart;
  logic       periodEnd;

  always_comb begin
    atStart          = enable && !running;
    periodEnd        = running && unitLast && (phaseIdx == lastPhaseIdx);
    strobe.holdIdle  = !enable;
    strobe.latchCfg  = enable && (atStart || periodEnd);
    strobe.startUnit = enable && (atStart || (running && unitLast));
    strobe.stepUnit  = enable && running && !unitLast;
    strobe.armSetup  = enable && stretchRelease;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      phaseIdx <= 2'd0;
      sclLevel <= 1'b1;
      lowTick  <= 1'b0;
      highTick <= 1'b0;
    end else if (!enable) begin
      running  <= 1'b0;
      phaseIdx <= 2'd0;
      sclLevel <= 1'b1;
      lowTick  <= 1'b0;
      highTick <= 1'b0;
    end else if (!running) begin
      running  <= 1'b1;
      phaseIdx <= 2'd0;
      sclLevel <= 1'b0;
      lowTick  <= 1'b1;
      highTick <= 1'b0;
    end else if (unitLast) begin
      if (phaseIdx == lastPhaseIdx) begin
        phaseIdx <= 2'd0;
        sclLevel <= 1'b0;
        lowTick  <= 1'b1;
        highTick <= 1'b0;
      end else begin
        phaseIdx <= phaseIdx + 2'd1;
        if (phaseIdx + 2'd1 == lastPhaseIdx) begin
          sclLevel <= 1'b1;
          lowTick  <= 1'b0;
          highTick <= 1'b1;
        end else begin
          sclLevel <= 1'b0;
          lowTick  <= 1'b1;
          highTick <= 1'b0;
        end
      end
    end else begin
      lowTick  <= 1'b0;
      highTick <= 1'b0;
    end
  end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        speedMode,
  input  logic [WORD_W-1:0] divWord,
  input  logic [WORD_W-1:0] setupWord,
  input  logic              stretchRelease,
  output logic              sclLevel,
  output logic              lowTick,
  output logic              highTick,
  output logic              setupDone
);

  dpStrobe_t  strobe;
  logic       unitLast;
  logic [1:0] lastPhaseIdx;

  sclgen_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .stretchRelease (stretchRelease),
    .unitLast       (unitLast),
    .lastPhaseIdx   (lastPhaseIdx),
    .strobe         (strobe),
    .sclLevel       (sclLevel),
    .lowTick        (lowTick),
    .highTick       (highTick)
  );

  sclgen_dp #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .speedMode    (speedMode),
    .divWord      (divWord),
    .setupWord    (setupWord),
    .unitLast     (unitLast),
    .lastPhaseIdx (lastPhaseIdx),
    .setupDone    (setupDone)
  );

endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic stretchRelease,
  input logic sclLevel,
  input logic lowTick,
  input logic highTick,
  input logic setupDone
);

  // R1: a disabled edge leaves the outputs released and quiet
  a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclLevel && !lowTick && !highTick && !setupDone));

  // R5: strobes are mutually exclusive
  a_r5_ticks_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(lowTick && highTick));

  // R3: a low strobe always coincides with SCL held low
  a_r3_low_tick_with_low_scl: assert property (@(posedge clk) disable iff (!rstN)
    lowTick |-> !sclLevel);

  // R5: SCL rises during operation only together with the high strobe
  a_r5_rise_has_high_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclLevel) && $past(enable)) |-> highTick);

  // R8: enabling starts a low phase on the next edge
  a_r8_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> (lowTick && !sclLevel));

  // R9: the setup completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> !setupDone);

endmodule

bind scl_rate_gen sclgen_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .enable         (enable),
  .stretchRelease (stretchRelease),
  .sclLevel       (sclLevel),
  .lowTick        (lowTick),
  .highTick       (highTick),
  .setupDone      (setupDone)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  speedMode = 2'd0;
  logic [31:0] divWord = 32'd0;
  logic [31:0] setupWord = 32'd0;
  logic        stretchRelease = 1'b0;
  logic        sclLevel, lowTick, highTick, setupDone;

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";
  bit    ended = 0;
  bit    started = 0;

  always #2.5 clk = ~clk;

  scl_rate_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .speedMode(speedMode),
    .divWord(divWord), .setupWord(setupWord), .stretchRelease(stretchRelease),
    .sclLevel(sclLevel), .lowTick(lowTick), .highTick(highTick),
    .setupDone(setupDone)
  );

  // reference model: one queue entry per cycle of the current period
  // entry bits: [2] scl level, [1] low strobe, [0] high strobe
  int q[$];
  int expBits = 4;
  bit expDone = 0;
  int cyc = 0;
  int deadline = -1;

  task automatic buildPeriod();
    int u, p;
    u = (speedMode == 2'd2) ? int'(divWord[31:16]) : int'(divWord[15:0]);
    if (u == 0) u = 1;
    p = (speedMode == 2'd0) ? 2 : 3;
    for (int k = 0; k < p; k++)
      for (int c = 0; c < u; c++)
        q.push_back(((k == p-1) ? 4 : 0) +
                    ((c == 0 && k < p-1) ? 2 : 0) +
                    ((c == 0 && k == p-1) ? 1 : 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (!rstN || !enable) begin
      q.delete();
      expBits = 4;
      deadline = -1;
      expDone = 0;
    end else begin
      if (q.size() == 0) buildPeriod();
      expBits = q.pop_front();
      if (stretchRelease) begin
        deadline = cyc + int'(setupWord[31:16]) + 1;
        expDone = 0;
      end else begin
        expDone = (cyc == deadline);
        if (expDone) deadline = -1;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !ended) begin
      total++;
      if (sclLevel !== expBits[2] || lowTick !== expBits[1] ||
          highTick !== expBits[0]) begin
        bad++;
        $display("FAIL %s cyc=%0d scl/low/high actual=%b%b%b expected=%b%b%b",
                 curReq, cyc, sclLevel, lowTick, highTick,
                 expBits[2], expBits[1], expBits[0]);
      end
      total++;
      if (setupDone !== expDone) begin
        bad++;
        $display("FAIL %s cyc=%0d setupDone actual=%b expected=%b",
                 curReq, cyc, setupDone, expDone);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release1();
    @(negedge clk);
    stretchRelease = 1'b1;
    @(negedge clk);
    stretchRelease = 1'b0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    curReq = "R1"; // reset state: released, no strobes
    step(4);
    rstN = 1'b1;
    step(3);

    curReq = "R3"; // standard, U=3, high half unused
    speedMode = 2'd0; divWord = {16'd7, 16'd3};
    enable = 1'b1;
    step(30);

    curReq = "R4"; // fast then fast-plus, across a disable
    enable = 1'b0; step(2);
    speedMode = 2'd1; divWord = {16'd9, 16'd2};
    enable = 1'b1; step(25);
    enable = 1'b0; step(2);
    speedMode = 2'd3; divWord = {16'd1, 16'd4};
    enable = 1'b1; step(30);

    curReq = "R2"; // high-speed picks the upper half
    enable = 1'b0; step(2);
    speedMode = 2'd2; divWord = {16'd5, 16'd9};
    enable = 1'b1; step(40);

    curReq = "R6"; // zero length behaves as one
    enable = 1'b0; step(2);
    speedMode = 2'd0; divWord = 32'd0;
    enable = 1'b1; step(12);
    speedMode = 2'd2; step(12);

    curReq = "R7"; // mid-period changes wait for the boundary
    enable = 1'b0; step(2);
    speedMode = 2'd0; divWord = {16'd2, 16'd6};
    enable = 1'b1; step(4);
    divWord = {16'd2, 16'd2}; step(3);
    speedMode = 2'd1; step(20);
    speedMode = 2'd2; divWord = {16'd3, 16'd8}; step(1);
    speedMode = 2'd0; step(30);

    curReq = "R1"; // disable mid-period, then idle
    step(3); enable = 1'b0; step(10);

    curReq = "R8"; // restart with new settings
    speedMode = 2'd1; divWord = {16'd0, 16'd1};
    enable = 1'b1; step(15);

    curReq = "R9"; // setup delay, low half junk
    setupWord = {16'd0, 16'hBEEF}; release1(); step(5);
    setupWord = {16'd3, 16'h1234}; release1(); step(8);
    setupWord = {16'd7, 16'hFFFF}; release1(); step(12);

    curReq = "R10"; // re-arm mid-count and back-to-back
    setupWord = {16'd5, 16'd0}; release1(); step(2);
    release1(); step(10);
    setupWord = {16'd0, 16'd0};
    @(negedge clk); stretchRelease = 1'b1;
    step(3); stretchRelease = 1'b0; step(4);

    curReq = "R1"; // disable cancels a running setup delay
    setupWord = {16'd6, 16'd0}; release1(); step(2);
    enable = 1'b0; step(10);

    finishRun();
  end

endmodule